// File: doc/BRIEF.md
# Bit-Plane Parallel Input Debouncer

This block cleans up a vector of noisy binary inputs, such as switch contacts, relay contacts or keypad lines. Each input has its own two-bit settle counter. The counters are not kept as one small register per input. Instead, all the least significant counter bits sit together in one register (the low plane) and all the most significant bits sit together in a second register (the high plane). A single pass of bitwise logic therefore advances every counter at once, whatever the width.

The block works only on cycles where `sample_en` is high. A periodic tick, for example one every few milliseconds, usually drives this strobe. On each strobe the block compares every raw input with its filtered value:

- If an input agrees with its filtered value, its counter returns to zero.
- If an input disagrees, its counter steps forward.
- When a disagreeing input's counter wraps back to zero, which happens on the fourth consecutive disagreeing strobe, the filtered value of that input flips.
- The block reports the flipped positions as a one-cycle mask.

Inputs are filtered independently. An input that chatters without end cannot hold back the others.

Top module: `vcd_debounce`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `state_o` equals the parameter `RESET_VAL` and `changed_o` is all zeros. Every counter starts at zero, so the first disagreement still needs four strobes.
- R2: On cycles where `sample_en` is low, `state_o` keeps its value and every counter keeps its count, whatever `raw_i` does.
- R3: An input's bit of `state_o` flips on the fourth consecutive strobe on which `raw_i` differs from it. It does not flip on the first, second or third such strobe.
- R4: A strobe on which an input agrees with its filtered value clears that input's counter. A disagreement lasting one to three strobes therefore leaves the state unchanged, and a later disagreement needs four strobes again.
- R5: In the clock cycle after each strobe, `changed_o` holds exactly the bit positions (bit i is input i) whose `state_o` bit flipped on that strobe. On every other cycle `changed_o` is zero.
- R6: Each bit is filtered on its own. An input that toggles on every strobe neither delays nor causes a flip of any other input.
- R7: Idle cycles between strobes do not break a run. Four disagreeing strobes separated by any number of cycles with `sample_en` low still produce the flip.
- R8: After a flip the counter of that input restarts from zero. Flipping back therefore needs four more disagreeing strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Strobe: one filter step on this cycle |
| raw_i | input | WIDTH | Unfiltered inputs |
| state_o | output | WIDTH | Filtered input values |
| changed_o | output | WIDTH | One-cycle mask of bits that flipped on the last strobe |

## Verification
The bench sweeps a four-bit instance through directed runs and a long pseudo-random pattern. Each strobe is compared against an arithmetic per-bit counter model. The corner cases covered, and the failure each one exposes, are:

- **Third-strobe boundary.** Counting one too few would flip one strobe early.
- **Three-strobe glitch followed by agreement.** Failing to clear on agreement would let two short glitches add up to a false flip.
- **Idle gaps inside a run.** Clearing on idle cycles would never flip when strobes are sparse.
- **Chattering neighbour beside a steady mismatch.** A shared counter would stall the steady input.
- **Cycle after each strobe.** A mask held longer than one cycle would report the same change twice.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

   // Next low plane: every counter flips its lowest bit.
   function automatic logic vcd_lo_step(input logic lo);
      return ~lo;
   endfunction

   // Next high plane: carry from the low plane.
   function automatic logic vcd_hi_step(input logic lo, input logic hi);
      return hi ^ lo;
   endfunction

endpackage

// File: rtl/vcd_plane_counter.sv
module vcd_plane_counter
   import vcd_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic [WIDTH-1:0] diff_i,
   output logic [WIDTH-1:0] lo_o,
   output logic [WIDTH-1:0] hi_o,
   output logic [WIDTH-1:0] wrap_o
);

   logic [WIDTH-1:0] lo_q, hi_q, lo_d, hi_d;

   // Bit-plane update: advance every counter, then clear the counters
   // of inputs that agree with their filtered value.
   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      always_comb begin
         hi_d[i]   = vcd_hi_step(lo_q[i], hi_q[i]) & diff_i[i];
         lo_d[i]   = vcd_lo_step(lo_q[i]) & diff_i[i];
         wrap_o[i] = diff_i[i] & ~hi_d[i] & ~lo_d[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (step_en) begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end

   assign lo_o = lo_q;
   assign hi_o = hi_q;

   AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> ((lo_q | hi_q) & ~$past(diff_i)) == '0); // R4

   AST_PLANES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> ($stable(lo_q) && $stable(hi_q))); // R2

endmodule

// File: rtl/vcd_state_reg.sv
module vcd_state_reg #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic [WIDTH-1:0] accept_i,
   output logic [WIDTH-1:0] state_o,
   output logic [WIDTH-1:0] changed_o
);

   logic [WIDTH-1:0] state_q, changed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= RESET_VAL;
         changed_q <= '0;
      end else if (step_en) begin
         state_q   <= state_q ^ accept_i;
         changed_q <= accept_i;
      end else begin
         changed_q <= '0;
      end
   end

   assign state_o   = state_q;
   assign changed_o = changed_q;

   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> changed_q == '0); // R5

   AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(state_q)); // R2

endmodule

// File: rtl/vcd_debounce.sv
module vcd_debounce #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] state_o,
   output logic [WIDTH-1:0] changed_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("vcd_debounce: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] diff, lo_plane, hi_plane, accept;

   assign diff = raw_i ^ state_o;

   vcd_plane_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (sample_en),
      .diff_i  (diff),
      .lo_o    (lo_plane),
      .hi_o    (hi_plane),
      .wrap_o  (accept)
   );

   vcd_state_reg #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (sample_en),
      .accept_i  (accept),
      .state_o   (state_o),
      .changed_o (changed_o)
   );

   AST_FLIP_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> (state_o ^ $past(state_o)) == changed_o); // R5

   AST_FLIP_ON_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> (changed_o & ~($past(lo_plane) & $past(hi_plane))) == '0); // R3

   AST_FLIP_ONLY_ON_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> (changed_o & ~$past(diff)) == '0); // R6

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (state_o == RESET_VAL && changed_o == '0)); // R1

endmodule

// File: tb/vcd_debounce_tb.sv
module vcd_debounce_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 4;
   localparam logic [W-1:0] RV = 4'b0101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample_en = 1'b0;
   logic [W-1:0] raw_i = RV;
   logic [W-1:0] state_o, changed_o;

   int checks = 0;
   int failures = 0;
   int mcnt [W];
   logic [W-1:0] mstate;
   logic [W-1:0] macc;

   always #(CLK_PERIOD/2) clk = ~clk;

   vcd_debounce #(.WIDTH(W), .RESET_VAL(RV)) u_dut (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
      .raw_i(raw_i), .state_o(state_o), .changed_o(changed_o));

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Arithmetic model of one strobe.
   task automatic model_step(input logic [W-1:0] r);
      macc = '0;
      for (int i = 0; i < W; i++) begin
         if (r[i] != mstate[i]) begin
            mcnt[i] = (mcnt[i] + 1) % 4;
            if (mcnt[i] == 0) macc[i] = 1'b1;
         end else begin
            mcnt[i] = 0;
         end
      end
      mstate = mstate ^ macc;
   endtask

   // One strobe; outputs compared one clock later, at the falling edge.
   task automatic strobe(input logic [W-1:0] r, input string tag);
      @(negedge clk);
      raw_i = r;
      sample_en = 1'b1;
      model_step(r);
      @(negedge clk);
      sample_en = 1'b0;
      check(state_o, mstate, tag);
      check(changed_o, macc, tag);
   endtask

   task automatic idle(input int n, input logic [W-1:0] r);
      logic [W-1:0] s;
      s = state_o;
      raw_i = r;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check(changed_o, '0, "R5 pulse clear idle");
         check(state_o, s, "R2 hold idle");
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] lfsr;
      logic [W-1:0] pat;
      logic b3;
      for (int i = 0; i < W; i++) mcnt[i] = 0;
      mstate = RV;
      repeat (3) @(negedge clk);
      check(state_o, RV, "R1 reset state");
      check(changed_o, '0, "R1 reset mask");
      rst_n = 1'b1;
      @(negedge clk);
      check(state_o, RV, "R1 after release");

      // R3: bit1 differs (RV bit1 = 0); three strobes then the fourth.
      strobe(RV | 4'b0010, "R3 strobe1");
      strobe(RV | 4'b0010, "R3 strobe2");
      strobe(RV | 4'b0010, "R3 strobe3");
      check(state_o, RV, "R3 no flip at third");
      strobe(RV | 4'b0010, "R3 strobe4");
      check(state_o, 4'b0111, "R3 flip at fourth");
      check(changed_o, 4'b0010, "R5 mask bit1");
      idle(2, 4'b0111);

      // R4: three-strobe glitch on bit0, agree once, three more: no flip.
      repeat (3) strobe(4'b0110, "R4 glitch a");
      strobe(4'b0111, "R4 agree clears");
      repeat (3) strobe(4'b0110, "R4 glitch b");
      check(state_o, 4'b0111, "R4 no flip");
      strobe(4'b0111, "R4 agree again");

      // R7: idle gaps inside a run; raw wiggles on idle cycles (R2).
      for (int k = 0; k < 4; k++) begin
         strobe(4'b1111, "R7 gapped run");
         idle(3, k[0] ? 4'b0000 : 4'b1111);
      end
      check(state_o, 4'b1111, "R7 flip after gapped run");

      // R8: flipping back needs four fresh strobes.
      repeat (3) strobe(4'b0111, "R8 back");
      check(state_o, 4'b1111, "R8 no early return");
      strobe(4'b0111, "R8 back4");
      check(state_o, 4'b0111, "R8 returned");

      // R6: bit3 chatters every strobe, bit2 held low steadily.
      b3 = 1'b0;
      for (int k = 0; k < 8; k++) begin
         b3 = ~b3;
         strobe({b3, 3'b011}, "R6 chatter");
         if (k == 3) check(state_o[2], 1'b0, "R6 steady bit flipped");
      end

      // Pseudo-random sweep against the model (R2, R3, R4, R5, R6).
      lfsr = 8'hA5;
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         // Bias toward holding the last pattern so runs of four occur.
         if (lfsr[7:6] == 2'b00) pat = lfsr[3:0];
         strobe(pat, "R3 R5 sweep");
         if (lfsr[1:0] == 2'b11) idle(1, ~pat);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule